// File: doc/BRIEF.md
# Status and Configuration Register Bank

This block is a register file that sits behind a simple memory-mapped bus with byte addressing, a 64-bit data path and one enable bit per byte lane. It presents two windows. The lower window holds 128 read-only status words, each fed live from the fabric. The upper window, starting at byte address 0x400, holds 128 read/write configuration words whose contents are driven back out to the fabric.

Each configuration word leaves reset at its own default value. Writes are accepted only when every byte lane is enabled. A write narrower than the full word, a write into the status window, and any access outside both windows are all dropped without a trace. A read returns registered data one clock after the strobe, together with a one-cycle valid pulse.

Software or a bus bridge uses the status window for monitoring. It uses the configuration window to steer logic elsewhere in the fabric, which reads the flat configuration output directly.

Top module: `regbank_top`

## Requirements
- R1: A read at byte address 8*i (i from 0 to 127) returns status word i as currently presented on the status input, where word i occupies bits [64*i+63:64*i].
- R2: A read at byte address 0x400 + 8*i (i from 0 to 127) returns the current content of configuration word i, which is also driven on bits [64*i+63:64*i] of the configuration output.
- R3: Under synchronous active-high reset every configuration word takes its own default: word 114 (address 0x790) resets to 0x1, and every other word resets to 0.
- R4: A write with all eight byte enables set (0xFF) to a configuration address stores the write data into that word, visible on the configuration output after the next clock edge.
- R5: A write with any byte enable clear leaves every configuration word unchanged.
- R6: A write to any address in the status window (0x000 to 0x3FF) changes no configuration word.
- R7: An address that is not 8-byte aligned, or that is at or above 0x800, reads as zero, and a write to it changes nothing.
- R8: The read-valid output is high exactly in the cycle after a read strobe, and read data is valid in that cycle.
- R9: All 64 bits of a configuration word are stored and read back as written, including bits the fabric does not use.
- R10: When a read and a full-width write hit the same configuration word in one cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 8 | Byte-lane enables of a write |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| bus_rvalid | output | 1 | High for one cycle when read data is valid |
| stat_in | input | 8192 | Flat status words from the fabric, word i at [64*i+63:64*i] |
| cfg_out | output | 8192 | Flat configuration words to the fabric, word i at [64*i+63:64*i] |

## Verification
The bench attacks the write qualification from both sides. It issues low-half and high-half partial writes over a stored word. A design that merged lanes would show a half-cleared word on readback. It also writes into the status window, above the configuration window and at a misaligned address, where loose decoding would corrupt a configuration word or alias one onto another. Reset defaults are checked at the word that resets nonzero and at its neighbour, which catches a shifted or missing default table. A same-cycle read and write to one word exposes read data taken after the update rather than before it.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int DATA_W      = 64;
    localparam int ADDR_W      = 16;
    localparam int STAT_COUNT  = 128;
    localparam int CFG_COUNT   = 128;
    localparam int CFG_BASE    = 'h400;
    localparam int MUX1_SEL_IX = 114;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_STAT = 2'd1,
        WIN_CFG  = 2'd2
    } win_e;

    // Reset value of one configuration word, selected by index.
    function automatic logic [63:0] cfg_reset_value(input int unsigned ix);
        logic [63:0] v;
        v = '0;
        if (ix == MUX1_SEL_IX) v = 64'h1;
        return v;
    endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
    import regbank_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int DW     = DATA_W,
    parameter int N_STAT = STAT_COUNT,
    parameter int N_CFG  = CFG_COUNT,
    parameter int BASE   = CFG_BASE,
    parameter int IW     = 7
) (
    input  logic [AW-1:0] addr,
    output win_e          win,
    output logic [IW-1:0] idx
);
    localparam int LANE_BITS = $clog2(DW / 8);
    localparam logic [AW:0] STAT_END = (AW+1)'(N_STAT * (DW / 8));
    localparam logic [AW:0] CFG_LO   = (AW+1)'(BASE);
    localparam logic [AW:0] CFG_END  = (AW+1)'(BASE + N_CFG * (DW / 8));

    logic [AW:0]   wide;
    logic [AW-1:0] rel;
    logic          aligned;

    always_comb begin
        wide    = {1'b0, addr};
        rel     = addr - AW'(BASE);
        aligned = (addr[LANE_BITS-1:0] == '0);
        win     = WIN_NONE;
        idx     = '0;
        if (aligned) begin
            if (wide < STAT_END) begin
                win = WIN_STAT;
                idx = addr[LANE_BITS +: IW];
            end else if (wide >= CFG_LO && wide < CFG_END) begin
                win = WIN_CFG;
                idx = rel[LANE_BITS +: IW];
            end
        end
    end
endmodule

// File: rtl/regbank_cfg_store.sv
module regbank_cfg_store
    import regbank_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int N_CFG = CFG_COUNT,
    parameter int IW    = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [IW-1:0]       widx,
    input  logic [DW-1:0]       wdata,
    output logic [N_CFG*DW-1:0] cfg_flat
);
    for (genvar g = 0; g < N_CFG; g++) begin : g_word
        localparam logic [DW-1:0] INIT = DW'(cfg_reset_value(g));
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= INIT;
            else if (we && widx == IW'(g))
                q <= wdata;
        end
        assign cfg_flat[g*DW +: DW] = q;
    end
endmodule

// File: rtl/regbank_rd_mux.sv
module regbank_rd_mux
    import regbank_pkg::*;
#(
    parameter int DW     = DATA_W,
    parameter int N_STAT = STAT_COUNT,
    parameter int N_CFG  = CFG_COUNT,
    parameter int IW     = 7
) (
    input  win_e                 win,
    input  logic [IW-1:0]        idx,
    input  logic [N_STAT*DW-1:0] stat_flat,
    input  logic [N_CFG*DW-1:0]  cfg_flat,
    output logic [DW-1:0]        word
);
    always_comb begin
        word = '0;
        unique case (win)
            WIN_STAT: word = stat_flat[idx*DW +: DW];
            WIN_CFG:  word = cfg_flat[idx*DW +: DW];
            default:  word = '0;
        endcase
    end
endmodule

// File: rtl/regbank_top.sv
module regbank_top
    import regbank_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int DW     = DATA_W,
    parameter int N_STAT = STAT_COUNT,
    parameter int N_CFG  = CFG_COUNT,
    parameter int BASE   = CFG_BASE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [AW-1:0]        bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [DW/8-1:0]      bus_be,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    output logic                 bus_rvalid,
    input  logic [N_STAT*DW-1:0] stat_in,
    output logic [N_CFG*DW-1:0]  cfg_out
);
    localparam int IW = (N_STAT > N_CFG) ? $clog2(N_STAT) : $clog2(N_CFG);

    win_e          win;
    logic [IW-1:0] idx;
    logic [DW-1:0] rd_word;
    logic          full_word;
    logic          cfg_we;

    regbank_decode #(
        .AW(AW), .DW(DW), .N_STAT(N_STAT), .N_CFG(N_CFG), .BASE(BASE), .IW(IW)
    ) u_decode (
        .addr (bus_addr),
        .win  (win),
        .idx  (idx)
    );

    // Only an access that enables every lane may modify a word.
    assign full_word = &bus_be;
    assign cfg_we    = bus_wr && full_word && (win == WIN_CFG);

    regbank_cfg_store #(
        .DW(DW), .N_CFG(N_CFG), .IW(IW)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .widx     (idx),
        .wdata    (bus_wdata),
        .cfg_flat (cfg_out)
    );

    regbank_rd_mux #(
        .DW(DW), .N_STAT(N_STAT), .N_CFG(N_CFG), .IW(IW)
    ) u_mux (
        .win       (win),
        .idx       (idx),
        .stat_flat (stat_in),
        .cfg_flat  (cfg_out),
        .word      (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) bus_rdata <= rd_word;
        end
    end
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
    import regbank_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int DW     = DATA_W,
    parameter int N_STAT = STAT_COUNT,
    parameter int N_CFG  = CFG_COUNT,
    parameter int BASE   = CFG_BASE
) (
    input logic                 clk,
    input logic                 rst,
    input logic [AW-1:0]        bus_addr,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [DW/8-1:0]      bus_be,
    input logic [DW-1:0]        bus_wdata,
    input logic [DW-1:0]        bus_rdata,
    input logic                 bus_rvalid,
    input logic [N_CFG*DW-1:0]  cfg_out
);
    localparam logic [AW:0] TOP_END  = (AW+1)'(BASE + N_CFG * (DW / 8));
    localparam logic [AW:0] STAT_END = (AW+1)'(N_STAT * (DW / 8));

    assert_rvalid_rise_R8: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);

    assert_rvalid_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !bus_rvalid);

    assert_partial_dropped_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !(&bus_be)) |=> $stable(cfg_out));

    assert_status_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && ({1'b0, bus_addr} < STAT_END)) |=> $stable(cfg_out));

    assert_outside_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && ({1'b0, bus_addr} >= TOP_END)) |=> (bus_rdata == '0));

    assert_full_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (&bus_be) && bus_addr == AW'(BASE)) |=>
            (cfg_out[DW-1:0] == $past(bus_wdata)));

    assert_reset_default_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cfg_out[MUX1_SEL_IX*DW +: DW] == DW'(1)));
endmodule

bind regbank_top regbank_chk #(
    .AW(AW), .DW(DW), .N_STAT(N_STAT), .N_CFG(N_CFG), .BASE(BASE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .cfg_out    (cfg_out)
);

// File: tb/tb_regbank_top.sv
module tb_regbank_top;

    localparam int NS = 128;
    localparam int NC = 128;

    localparam logic [1:0] K_WR  = 2'd0;
    localparam logic [1:0] K_RD  = 2'd1;
    localparam logic [1:0] K_RDS = 2'd2;

    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] addr;
        logic [7:0]  be;
        logic [63:0] data;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{K_RDS, 16'h0000, 8'h00, 64'h0, "R1 "},
        '{K_RDS, 16'h03F8, 8'h00, 64'h0, "R1 "},
        '{K_RD,  16'h0790, 8'h00, 64'h1, "R3 "},
        '{K_RD,  16'h0788, 8'h00, 64'h0, "R3 "},
        '{K_WR,  16'h0400, 8'hFF, 64'hDEAD_BEEF_0123_4567, "R4 "},
        '{K_RD,  16'h0400, 8'h00, 64'hDEAD_BEEF_0123_4567, "R2 "},
        '{K_WR,  16'h0400, 8'h0F, 64'h0, "R5 "},
        '{K_RD,  16'h0400, 8'h00, 64'hDEAD_BEEF_0123_4567, "R5 "},
        '{K_WR,  16'h0400, 8'hF0, 64'h0, "R5 "},
        '{K_RD,  16'h0400, 8'h00, 64'hDEAD_BEEF_0123_4567, "R5 "},
        '{K_WR,  16'h07F8, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, "R9 "},
        '{K_RD,  16'h07F8, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, "R9 "},
        '{K_RD,  16'h0800, 8'h00, 64'h0, "R7 "},
        '{K_RD,  16'h0404, 8'h00, 64'h0, "R7 "}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [15:0]    bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [7:0]     bus_be = '0;
    logic [63:0]    bus_wdata = '0;
    logic [63:0]    bus_rdata;
    logic           bus_rvalid;
    logic [NS*64-1:0] stat_in;
    logic [NC*64-1:0] cfg_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    regbank_top dut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_be     (bus_be),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .stat_in    (stat_in),
        .cfg_out    (cfg_out)
    );

    function automatic logic [63:0] stat_pat(input int i);
        return {16'hC0DE, 16'(i), 16'h5A5A, 16'(i * 3 + 1)};
    endfunction

    initial begin
        for (int i = 0; i < NS; i++) stat_in[i*64 +: 64] = stat_pat(i);
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [7:0] be, input logic [63:0] d);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic do_rd(input logic [15:0] a, output logic [63:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [63:0]      rd;
        logic [NC*64-1:0] snap;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state: R3 defaults and idle R8 valid
        check("R3", "word 114 default", cfg_out[114*64 +: 64], 64'h1);
        check("R3", "word 0 default",   cfg_out[0 +: 64],      64'h0);
        check("R3", "word 113 default", cfg_out[113*64 +: 64], 64'h0);
        check("R8", "rvalid idle after reset", 64'(bus_rvalid), 64'h0);

        // Vector table
        for (int k = 0; k < NV; k++) begin
            if (VECS[k].kind == K_WR) begin
                do_wr(VECS[k].addr, VECS[k].be, VECS[k].data);
            end else begin
                do_rd(VECS[k].addr, rd);
                check($sformatf("%s", VECS[k].tag), $sformatf("row %0d read", k), rd,
                      (VECS[k].kind == K_RDS) ? stat_pat(int'(VECS[k].addr >> 3)) : VECS[k].data);
                check("R8", $sformatf("row %0d rvalid", k), 64'(bus_rvalid), 64'h1);
            end
        end

        // R4: full write visible on the fabric output
        check("R4", "cfg_out word 0", cfg_out[0 +: 64], 64'hDEAD_BEEF_0123_4567);
        check("R2", "cfg_out word 127", cfg_out[127*64 +: 64], 64'hFFFF_FFFF_FFFF_FFFF);

        // R8: valid is a single-cycle pulse
        @(negedge clk);
        check("R8", "rvalid drops after pulse", 64'(bus_rvalid), 64'h0);

        // R6: status-window write is ignored
        snap = cfg_out;
        do_wr(16'h0010, 8'hFF, 64'h5555_5555_5555_5555);
        check("R6", "cfg unchanged after status write", 64'(cfg_out == snap), 64'h1);
        do_rd(16'h0010, rd);
        check("R6", "status word 2 after write", rd, stat_pat(2));

        // R7: out-of-window and misaligned writes are ignored
        do_wr(16'h0800, 8'hFF, 64'h1111_2222_3333_4444);
        check("R7", "cfg unchanged after high write", 64'(cfg_out == snap), 64'h1);
        do_wr(16'h0403, 8'hFF, 64'h7777_7777_7777_7777);
        check("R7", "cfg unchanged after misaligned write", 64'(cfg_out == snap), 64'h1);

        // R10: same-cycle read and write of word 5
        do_wr(16'h0428, 8'hFF, 64'hAAAA_0000_0000_0001);
        @(negedge clk);
        bus_addr = 16'h0428; bus_be = 8'hFF; bus_wdata = 64'hBBBB_0000_0000_0002;
        bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_be = '0;
        check("R10", "read returns pre-write value", bus_rdata, 64'hAAAA_0000_0000_0001);
        check("R10", "word 5 updated", cfg_out[5*64 +: 64], 64'hBBBB_0000_0000_0002);

        finish_run();
    end

endmodule